// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block watches a port of already-synchronized input pins and raises one combined interrupt when any pin shows the condition chosen for it. Each pin owns a control word on a simple 32-bit register bus. A 4-bit trigger field in that word selects one of five trigger kinds: low level, high level, rising edge, falling edge or either edge. All other field values turn detection off for the pin.

Detected events land in a shared status-flag word with one bit per pin. Software clears these bits by writing ones. A registered OR of every flag drives the single interrupt output. Level triggers keep setting their flag for as long as the level persists, so a service routine must first remove the cause and then clear the flag. Edge triggers compare each pin with its own value one cycle earlier.

Top module: `pin_irq_detector`

## Requirements
- R1: After reset every status flag is 0, the interrupt output is 0 and every control word reads back as 0.
- R2: The control word of pin n sits at byte offset 4*n. Its trigger field occupies bits 19:16 and reads back as written. All other bits of a control word read as 0.
- R3: Trigger code 0x8 sets the pin's flag on every cycle the pin is low, so a clear written while the pin is still low leaves the flag at 1.
- R4: Trigger code 0x9 sets the flag when the pin is 1 and was 0 on the previous cycle. A falling transition sets nothing.
- R5: Trigger code 0xA sets the flag when the pin is 0 and was 1 on the previous cycle. A rising transition sets nothing.
- R6: Trigger code 0xB sets the flag on both a rising and a falling transition.
- R7: Trigger code 0xC sets the flag on every cycle the pin is high, so a clear written while the pin is still high leaves the flag at 1.
- R8: Trigger code 0x0, and every code not listed in R3 to R7 (for example 0x3 or 0xF), never sets a flag.
- R9: The status-flag word is at byte offset 0xA0, with bit n belonging to pin n. Writing a 1 to a bit clears it, writing a 0 leaves it unchanged, and writing all ones clears every flag.
- R10: When a pin's event and a clear of its flag happen in the same cycle, the flag ends up at 1.
- R11: The interrupt output equals the OR of all status flags, delayed by one clock cycle.
- R12: Writing 0 to a pin's control word stops any new flag for that pin and leaves a flag that is already set unchanged.
- R13: A read returns its data one cycle after the read strobe. Offsets that hold no register read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | NPINS | Synchronized pin levels |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Combined port interrupt |

## Verification
The bench builds the block with its default parameters: 32 pins, an 8-bit byte address and a 32-bit data word. These values let the tests reach the highest pin, whose control word is at offset 0x7C and whose flag is bit 31 of the flag word. They also let the tests probe the unmapped gap between the last control word and the flag word at 0xA0. With the full-width flag word, the all-ones clear and partial clears across several simultaneous flags can be checked directly. The same settings cover the single-cycle collision between a fresh edge and a clear write.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        TRIG_OFF  = 4'h0,
        TRIG_LOW  = 4'h8,
        TRIG_RISE = 4'h9,
        TRIG_FALL = 4'hA,
        TRIG_BOTH = 4'hB,
        TRIG_HIGH = 4'hC
    } trig_mode_e;

    // Event decision for one pin: current level, level one cycle earlier.
    function automatic logic trig_event(input logic [MODE_W-1:0] mode,
                                        input logic cur,
                                        input logic prev);
        logic hit;
        case (mode)
            TRIG_LOW:  hit = ~cur;
            TRIG_RISE: hit = cur & ~prev;
            TRIG_FALL: hit = ~cur & prev;
            TRIG_BOTH: hit = cur ^ prev;
            TRIG_HIGH: hit = cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic trig_known(input logic [MODE_W-1:0] mode);
        return (mode == TRIG_LOW) || (mode == TRIG_RISE) || (mode == TRIG_FALL) ||
               (mode == TRIG_BOTH) || (mode == TRIG_HIGH);
    endfunction

endpackage

// File: rtl/pin_cfg_regs.sv
module pin_cfg_regs
    import pin_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [MODE_W-1:0]             wr_field,
    output logic                          ctrl_hit,
    output logic [MODE_W-1:0]             sel_mode,
    output logic [NPINS-1:0][MODE_W-1:0]  mode_vec
);

    localparam int IDX_W     = $clog2(NPINS);
    localparam int CTRL_SPAN = NPINS * 4;

    typedef struct packed {
        logic [NPINS-1:0][MODE_W-1:0] mode;
    } cfg_state_t;

    cfg_state_t        st_d, st_q;
    logic [IDX_W-1:0]  idx;

    assign idx      = addr[2 +: IDX_W];
    assign ctrl_hit = (addr[1:0] == 2'b00) && (int'(addr) < CTRL_SPAN);
    assign sel_mode = st_q.mode[idx];
    assign mode_vec = st_q.mode;

    always_comb begin
        st_d = st_q;
        if (wr_en && ctrl_hit) begin
            st_d.mode[idx] = wr_field;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect
    import pin_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPINS-1:0]              pin_lvl,
    input  logic [NPINS-1:0][MODE_W-1:0]  mode_vec,
    output logic [NPINS-1:0]              evt
);

    typedef struct packed {
        logic [NPINS-1:0] prev;
    } det_state_t;

    det_state_t st_d, st_q;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        assign evt[g] = trig_event(mode_vec[g], pin_lvl[g], st_q.prev[g]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] evt,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] flags,
    output logic             irq
);

    typedef struct packed {
        logic [NPINS-1:0] flags;
        logic             irq;
    } flag_state_t;

    flag_state_t st_d, st_q;

    assign flags = st_q.flags;
    assign irq   = st_q.irq;

    always_comb begin
        st_d       = st_q;
        // a fresh event outranks a clear in the same cycle
        st_d.flags = (st_q.flags & ~clr) | evt;
        st_d.irq   = |st_q.flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pin_irq_detector.sv
module pin_irq_detector
    import pin_irq_pkg::*;
#(
    parameter int                 NPINS    = 32,
    parameter int                 ADDR_W   = 8,
    parameter int                 DATA_W   = 32,
    parameter int                 MODE_LSB = 16,
    parameter logic [ADDR_W-1:0]  STAT_OFS = 8'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_lvl,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t                    st_d, st_q;
    logic                         ctrl_hit;
    logic                         stat_hit;
    logic [MODE_W-1:0]            sel_mode;
    logic [NPINS-1:0][MODE_W-1:0] mode_vec;
    logic [NPINS-1:0]             evt_vec;
    logic [NPINS-1:0]             clr_vec;
    logic [NPINS-1:0]             flag_vec;

    assign stat_hit = (bus_addr == STAT_OFS);
    assign clr_vec  = (bus_wr && stat_hit) ? bus_wdata[NPINS-1:0] : '0;

    pin_cfg_regs #(
        .NPINS  (NPINS),
        .ADDR_W (ADDR_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wr_field (bus_wdata[MODE_LSB +: MODE_W]),
        .ctrl_hit (ctrl_hit),
        .sel_mode (sel_mode),
        .mode_vec (mode_vec)
    );

    pin_event_detect #(
        .NPINS (NPINS)
    ) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_lvl  (pin_lvl),
        .mode_vec (mode_vec),
        .evt      (evt_vec)
    );

    irq_flag_bank #(
        .NPINS (NPINS)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_vec),
        .clr   (clr_vec),
        .flags (flag_vec),
        .irq   (irq)
    );

    always_comb begin
        st_d = st_q;
        if (bus_rd) begin
            st_d.rdata = '0;
            if (ctrl_hit) begin
                st_d.rdata[MODE_LSB +: MODE_W] = sel_mode;
            end else if (stat_hit) begin
                st_d.rdata[NPINS-1:0] = flag_vec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/pin_irq_checker.sv
module pin_irq_checker
    import pin_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NPINS-1:0]              pin_lvl,
    input logic [NPINS-1:0][MODE_W-1:0]  mode_vec,
    input logic [NPINS-1:0]              evt,
    input logic [NPINS-1:0]              clr,
    input logic [NPINS-1:0]              flags,
    input logic                          irq
);

    p_irq_or_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|$past(flags)));

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[g] && clr[g]) |=> flags[g]);

        p_w1c_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !evt[g]) |=> !flags[g]);

        p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[g] && !evt[g]) |=> (flags[g] == $past(flags[g])));

        p_off_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !trig_known(mode_vec[g]) |-> !evt[g]);

        p_rise_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_vec[g] == TRIG_RISE && pin_lvl[g] && !$past(pin_lvl[g])) |-> evt[g]);

        p_high_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_vec[g] == TRIG_HIGH && pin_lvl[g]) |-> evt[g]);
    end

endmodule

bind pin_irq_detector pin_irq_checker #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl  (pin_lvl),
    .mode_vec (mode_vec),
    .evt      (evt_vec),
    .clr      (clr_vec),
    .flags    (flag_vec),
    .irq      (irq)
);

// File: tb/pin_irq_detector_test.sv
`timescale 1ns/1ps
module pin_irq_detector_test;

    localparam int NPINS = 32;
    localparam logic [7:0] STAT = 8'hA0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pin_irq_detector uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl   (pins),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_mode(input int pin, input logic [3:0] m);
        wr(8'(pin * 4), {12'h0, m, 16'h0});
    endtask

    task automatic test_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(STAT, d);           check("R1 flags", d, 32'h0);
        rd(8'h14, d);          check("R1 ctrl5", d, 32'h0);
    endtask

    task automatic test_cfg_map();
        logic [31:0] d;
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, d);          check("R2 pin5 field only", d, 32'h000F_0000);
        wr(8'h7C, 32'h0009_1234);
        rd(8'h7C, d);          check("R2 pin31 at 0x7C", d, 32'h0009_0000);
        rd(8'h78, d);          check("R2 neighbour pin30 untouched", d, 32'h0);
        wr(8'h14, 32'h0);
        wr(8'h7C, 32'h0);
        rd(8'h90, d);          check("R13 unmapped 0x90", d, 32'h0);
        rd(8'hA4, d);          check("R13 unmapped 0xA4", d, 32'h0);
    endtask

    task automatic test_rise();
        logic [31:0] d;
        set_mode(3, 4'h9);
        pins[3] = 1'b1;
        tick();
        check("R11 irq lags flag", {31'b0, irq}, 32'h0);
        rd(STAT, d);           check("R4 rise sets flag", d, 32'h8);
        check("R11 irq after flag", {31'b0, irq}, 32'h1);
        wr(STAT, 32'h8);
        rd(STAT, d);           check("R9 w1c clears", d, 32'h0);
        pins[3] = 1'b0;
        tick();
        rd(STAT, d);           check("R4 fall ignored", d, 32'h0);
        tick();
        check("R11 irq drops", {31'b0, irq}, 32'h0);
        set_mode(3, 4'h0);
    endtask

    task automatic test_fall();
        logic [31:0] d;
        set_mode(7, 4'hA);
        pins[7] = 1'b1;
        tick(); tick();
        rd(STAT, d);           check("R5 rise ignored", d, 32'h0);
        pins[7] = 1'b0;
        tick();
        rd(STAT, d);           check("R5 fall sets flag", d, 32'h80);
        wr(STAT, 32'hFFFF_FFFF);
        set_mode(7, 4'h0);
    endtask

    task automatic test_both();
        logic [31:0] d;
        set_mode(12, 4'hB);
        pins[12] = 1'b1;
        tick();
        rd(STAT, d);           check("R6 rise", d, 32'h1000);
        wr(STAT, 32'h1000);
        pins[12] = 1'b0;
        tick();
        rd(STAT, d);           check("R6 fall", d, 32'h1000);
        wr(STAT, 32'h1000);
        set_mode(12, 4'h0);
    endtask

    task automatic test_level_low();
        logic [31:0] d;
        set_mode(20, 4'h8);
        tick();
        wr(STAT, 32'h0010_0000);
        rd(STAT, d);           check("R3 low level re-sets", d, 32'h0010_0000);
        pins[20] = 1'b1;
        tick();
        wr(STAT, 32'h0010_0000);
        rd(STAT, d);           check("R3 cleared once high", d, 32'h0);
        set_mode(20, 4'h0);
        pins[20] = 1'b0;
    endtask

    task automatic test_level_high();
        logic [31:0] d;
        set_mode(31, 4'hC);
        pins[31] = 1'b1;
        tick();
        wr(STAT, 32'h8000_0000);
        rd(STAT, d);           check("R7 high level re-sets", d, 32'h8000_0000);
        pins[31] = 1'b0;
        tick();
        wr(STAT, 32'h8000_0000);
        rd(STAT, d);           check("R7 cleared once low", d, 32'h0);
        set_mode(31, 4'h0);
    endtask

    task automatic test_disabled();
        logic [31:0] d;
        set_mode(2, 4'h3);
        pins[2] = 1'b1; tick(); pins[2] = 1'b0; tick();
        rd(STAT, d);           check("R8 code 0x3 silent", d, 32'h0);
        set_mode(2, 4'hF);
        pins[2] = 1'b1; tick(); pins[2] = 1'b0; tick();
        rd(STAT, d);           check("R8 code 0xF silent", d, 32'h0);
        set_mode(2, 4'h9);
        pins[2] = 1'b1; tick(); pins[2] = 1'b0; tick();
        wr(8'h08, 32'h0);
        rd(STAT, d);           check("R12 old flag kept", d, 32'h4);
        wr(STAT, 32'h4);
        pins[2] = 1'b1; tick(); pins[2] = 1'b0; tick();
        rd(STAT, d);           check("R12 no new flag", d, 32'h0);
    endtask

    task automatic test_partial_clear();
        logic [31:0] d;
        set_mode(4, 4'h9); set_mode(5, 4'h9); set_mode(6, 4'h9);
        pins[6:4] = 3'b111;
        tick();
        wr(STAT, 32'h20);
        rd(STAT, d);           check("R9 partial clear", d, 32'h50);
        wr(STAT, 32'h0);
        rd(STAT, d);           check("R9 zero write no effect", d, 32'h50);
        wr(STAT, 32'hFFFF_FFFF);
        rd(STAT, d);           check("R9 all ones clears", d, 32'h0);
        set_mode(4, 4'h0); set_mode(5, 4'h0); set_mode(6, 4'h0);
        pins[6:4] = 3'b000;
        tick();
    endtask

    task automatic test_set_wins();
        logic [31:0] d;
        set_mode(9, 4'h9);
        pins[9] = 1'b1; tick(); pins[9] = 1'b0; tick();
        pins[9] = 1'b1;
        wr(STAT, 32'h200);
        rd(STAT, d);           check("R10 set beats clear", d, 32'h200);
        wr(STAT, 32'h200);
        rd(STAT, d);           check("R10 plain clear after", d, 32'h0);
        set_mode(9, 4'h0);
        pins[9] = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        test_reset();
        test_cfg_map();
        test_rise();
        test_fall();
        test_both();
        test_level_low();
        test_level_high();
        test_disabled();
        test_partial_clear();
        test_set_wins();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule